// File: doc/BRIEF.md
# Two-Wire Control Register Slave with Counted Block Transfers

This block is the serial configuration port of a multi-output clock generator. It sits on a two-wire bus as a slave and gives a bus master access to six 8-bit control registers. The slave pulls the data line low through an open-drain enable and never drives it high. Both bus lines are oversampled by the block's own faster clock. A START or STOP condition is recognised when SDA changes while SCL is high.

A transaction always opens with the write address and a command byte. Bit 7 of the command selects the access form: set means single-byte access, clear means counted block access. Bits 6:0 give the first register index. A block write then carries a byte count ahead of its data. A block read, after a repeated START and the read address, returns the byte-count register before the data bytes. Register contents drive the clock output enables and the output amplitude controls of the rest of the device. A power-down input holds the whole block in its reset state.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: After reset all six registers hold index 0 = 00h, 1 = 17h, 2 = F8h, 3 = 08h, 4 = 06h, 5 = D8h, and the slave does not pull SDA low.
- R2: The slave acknowledges only address byte D6h (7-bit address 6Bh, write) and D7h (read). For any other address it never pulls SDA low, and the registers do not change.
- R3: Byte write: the master sends D6h, a command with bit 7 set and index in bits 6:0, and one data byte. The slave acknowledges every byte and writes the data into that register. Registers change only while SCL is low.
- R4: Byte read: the master sends D6h, a command with bit 7 set, a repeated START and D7h. The slave then sends the register at that index, MSB first.
- R5: Block write: the master sends D6h, a command with bit 7 clear, a count byte N, and data bytes. Data bytes fill consecutive registers upward from the index. Bytes after the first N are acknowledged and discarded.
- R6: Block read: the master sends D6h, a command with bit 7 clear, a repeated START and D7h. The first byte returned is the content of register 4, followed by the registers from the index upward for as long as the master acknowledges.
- R7: Only these bits can be written: register 0 none (mask 00h), register 1 mask 17h, register 2 mask F8h, registers 3 and 4 all bits, register 5 mask F0h. The other bits keep their reset values.
- R8: Writes to indices above 5 are acknowledged and have no effect, and reads of those indices return 00h.
- R9: A STOP after any complete data byte ends a block write. The bytes already written stay written and later registers are untouched.
- R10: While `pwr_down` is high, every register returns to and stays at its reset value and SDA is released.
- R11: The register image is exported: `out_en[0]` = reg1 bit 4; `out_en[1..3]` = reg1 bits 2, 1, 0; `out_en[4..8]` = reg2 bits 7 down to 3; `amp_sel` = reg5 bit 7; `amp_code` = reg5 bits 6:4.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Holds the block in reset state while high |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When high, the slave pulls SDA low |
| regs_flat | output | 48 | Register image, register k in bits 8k+7:8k |
| out_en | output | 9 | Per-output clock enable bits |
| amp_sel | output | 1 | Selects programmed output amplitude |
| amp_code | output | 3 | Programmed amplitude step |

## Verification
The bench runs all four transaction forms through a bus model with a wired-AND data line. It varies the index, the count and the number of bytes the master actually sends. A block write with more data than its count separates count-limited writing from free-running writing, and a block write cut short by STOP separates per-byte commits from commits at the end of the transaction. A block read after reprogramming register 4 tells the count byte apart from ordinary data. Reads that run past index 5, writes of all-ones and all-zeros patterns against the reserved masks, and a foreign address probe the boundary behaviour.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int NUM_REGS      = 6;
    localparam int NUM_OUTS      = 9;
    localparam int CMD_IDX_BITS  = 7;
    localparam int IDX_W         = CMD_IDX_BITS + 1;
    localparam int CNT_REG       = 4;
    localparam int OE_LO_REG     = 1;
    localparam int OE_HI_REG     = 2;
    localparam int AMP_REG       = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

    typedef enum logic [1:0] {
        RK_CMD,
        RK_COUNT,
        RK_DATA
    } rx_kind_e;

    function automatic logic [7:0] reg_reset(input int i);
        case (i)
            1:       return 8'h17;
            2:       return 8'hF8;
            3:       return 8'h08;
            4:       return 8'h06;
            5:       return 8'hD8;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_wmask(input int i);
        case (i)
            1:       return 8'h17;
            2:       return 8'hF8;
            3:       return 8'hFF;
            4:       return 8'hFF;
            5:       return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop,
    output logic sda_lvl
);

    typedef struct packed {
        logic [STAGES:0] scl;
        logic [STAGES:0] sda;
    } sync_t;

    sync_t s_d, s_q;
    logic  scl_now, scl_old, sda_now, sda_old;

    always_comb begin
        s_d     = s_q;
        s_d.scl = {s_q.scl[STAGES-1:0], scl_i};
        s_d.sda = {s_q.sda[STAGES-1:0], sda_i};
        if (hold) begin
            s_d.scl = '1;
            s_d.sda = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_now   = s_q.scl[STAGES-1];
    assign scl_old   = s_q.scl[STAGES];
    assign sda_now   = s_q.sda[STAGES-1];
    assign sda_old   = s_q.sda[STAGES];

    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign bus_start = scl_now & scl_old & sda_old & ~sda_now;
    assign bus_stop  = scl_now & scl_old & ~sda_old & sda_now;
    assign sda_lvl   = sda_now;

endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank
    import clkcfg_pkg::*;
#(
    parameter int N = NUM_REGS,
    parameter int W = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [W-1:0]     rd_idx,
    output logic [7:0]       rd_data,
    output logic [8*N-1:0]   image
);

    for (genvar g = 0; g < N; g++) begin : g_reg
        localparam logic [7:0] RV = reg_reset(g);
        localparam logic [7:0] WM = reg_wmask(g);
        logic [7:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (wr_en && (wr_idx == W'(g))) begin
                r_d = (r_q & ~WM) | (wr_data & WM);
            end
            if (hold) begin
                r_d = RV;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= RV;
            end else begin
                r_q <= r_d;
            end
        end

        assign image[8*g +: 8] = r_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == W'(i)) begin
                rd_data = image[8*i +: 8];
            end
        end
    end

endmodule

// File: rtl/clkcfg_bus_fsm.sv
module clkcfg_bus_fsm
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6B,
    parameter int         W        = IDX_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         scl_rise,
    input  logic         scl_fall,
    input  logic         bus_start,
    input  logic         bus_stop,
    input  logic         sda_lvl,
    input  logic [7:0]   rd_data,
    input  logic [7:0]   cnt_val,
    output logic         wr_en,
    output logic [W-1:0] wr_idx,
    output logic [7:0]   wr_data,
    output logic [W-1:0] rd_idx,
    output logic         sda_oe
);

    typedef struct packed {
        bus_state_e  st;
        logic [2:0]  bit_cnt;
        logic        got;
        logic [7:0]  sh;
        logic        rw;
        rx_kind_e    kind;
        logic        blk;
        logic [7:0]  remain;
        logic [W-1:0] idx;
        logic        oe;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        st: ST_IDLE, bit_cnt: '0, got: 1'b0, sh: '0, rw: 1'b0,
        kind: RK_CMD, blk: 1'b0, remain: '0, idx: '0, oe: 1'b0
    };

    fsm_t d, q;

    function automatic logic [W-1:0] step_idx(input logic [W-1:0] i);
        return (i == '1) ? i : i + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_idx  = q.idx;
        wr_data = q.sh;
        rd_idx  = q.idx;

        if (bus_stop) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.got = 1'b0;
        end else if (bus_start) begin
            d.st      = ST_ADDR;
            d.bit_cnt = '0;
            d.got     = 1'b0;
            d.oe      = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        d.sh      = {q.sh[6:0], sda_lvl};
                        d.bit_cnt = q.bit_cnt + 3'd1;
                        if (q.bit_cnt == 3'd7) d.got = 1'b1;
                    end else if (scl_fall && q.got) begin
                        d.got = 1'b0;
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.st = ST_ADDR_ACK;
                                d.rw = q.sh[0];
                                d.oe = 1'b1;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st = ST_RX_ACK;
                            d.oe = 1'b1;
                            case (q.kind)
                                RK_CMD: begin
                                    d.idx    = W'(q.sh[CMD_IDX_BITS-1:0]);
                                    d.blk    = ~q.sh[7];
                                    d.kind   = q.sh[7] ? RK_DATA : RK_COUNT;
                                    d.remain = q.sh[7] ? 8'd1 : 8'd0;
                                end
                                RK_COUNT: begin
                                    d.remain = q.sh;
                                    d.kind   = RK_DATA;
                                end
                                default: begin
                                    if (q.remain != 8'd0) begin
                                        wr_en    = 1'b1;
                                        d.remain = q.remain - 8'd1;
                                        d.idx    = step_idx(q.idx);
                                    end
                                end
                            endcase
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.bit_cnt = '0;
                        if (q.rw) begin
                            d.st = ST_TX;
                            if (q.blk) begin
                                d.sh = cnt_val;
                            end else begin
                                d.sh  = rd_data;
                                d.idx = step_idx(q.idx);
                            end
                            d.oe = q.blk ? ~cnt_val[7] : ~rd_data[7];
                        end else begin
                            d.st   = ST_RX;
                            d.kind = RK_CMD;
                            d.oe   = 1'b0;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.st      = ST_RX;
                        d.bit_cnt = '0;
                        d.oe      = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bit_cnt = q.bit_cnt + 3'd1;
                        if (q.bit_cnt == 3'd7) d.got = 1'b1;
                    end else if (scl_fall) begin
                        if (q.got) begin
                            d.st  = ST_TX_ACK;
                            d.got = 1'b0;
                            d.oe  = 1'b0;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) d.st = ST_IDLE;
                        else         d.got = 1'b1;
                    end else if (scl_fall && q.got) begin
                        d.got     = 1'b0;
                        d.st      = ST_TX;
                        d.bit_cnt = '0;
                        d.sh      = rd_data;
                        d.idx     = step_idx(q.idx);
                        d.oe      = ~rd_data[7];
                    end
                end
                default: begin
                end
            endcase
        end

        if (hold) begin
            d     = FSM_RST;
            wr_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= FSM_RST;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h6B,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_down,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [8*NUM_REGS-1:0] regs_flat,
    output logic [NUM_OUTS-1:0]   out_en,
    output logic                  amp_sel,
    output logic [2:0]            amp_code
);

    localparam int LO_OUTS = 4;
    localparam int HI_OUTS = NUM_OUTS - LO_OUTS;

    logic             scl_rise, scl_fall, bus_start, bus_stop, sda_lvl;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;
    logic [7:0]       lo_reg, hi_reg, amp_reg;

    clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (pwr_down),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .sda_lvl   (sda_lvl)
    );

    clkcfg_bus_fsm #(.DEV_ADDR(DEV_ADDR), .W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (pwr_down),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .sda_lvl   (sda_lvl),
        .rd_data   (rd_data),
        .cnt_val   (regs_flat[8*CNT_REG +: 8]),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .sda_oe    (sda_oe)
    );

    clkcfg_reg_bank #(.N(NUM_REGS), .W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (pwr_down),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .image   (regs_flat)
    );

    assign lo_reg  = regs_flat[8*OE_LO_REG +: 8];
    assign hi_reg  = regs_flat[8*OE_HI_REG +: 8];
    assign amp_reg = regs_flat[8*AMP_REG +: 8];

    assign out_en[0] = lo_reg[4];
    for (genvar k = 1; k < LO_OUTS; k++) begin : g_oe_lo
        assign out_en[k] = lo_reg[LO_OUTS-1-k];
    end
    for (genvar k = 0; k < HI_OUTS; k++) begin : g_oe_hi
        assign out_en[LO_OUTS+k] = hi_reg[7-k];
    end

    assign amp_sel  = amp_reg[7];
    assign amp_code = amp_reg[6:4];

endmodule

// File: rtl/clkcfg_serial_slave_chk.sv
module clkcfg_serial_slave_chk
    import clkcfg_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pwr_down,
    input logic                  scl_i,
    input logic                  sda_oe,
    input logic [8*NUM_REGS-1:0] regs_flat
);

    function automatic logic [8*NUM_REGS-1:0] reset_image();
        logic [8*NUM_REGS-1:0] v;
        for (int i = 0; i < NUM_REGS; i++) v[8*i +: 8] = reg_reset(i);
        return v;
    endfunction

    function automatic logic fixed_bits_ok(input logic [8*NUM_REGS-1:0] img);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_REGS; i++) begin
            if ((img[8*i +: 8] & ~reg_wmask(i)) != (reg_reset(i) & ~reg_wmask(i))) ok = 1'b0;
        end
        return ok;
    endfunction

    localparam logic [8*NUM_REGS-1:0] RST_IMG = reset_image();

    AST_PWRDN_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !sda_oe); // R10

    AST_PWRDN_RESET_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (regs_flat == RST_IMG)); // R10

    AST_FIXED_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_bits_ok(regs_flat)); // R7

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(pwr_down)) |-> !scl_i); // R12

    AST_REG_UPDATE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(regs_flat) && !$past(pwr_down)) |-> !scl_i); // R3

endmodule

bind clkcfg_serial_slave clkcfg_serial_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .regs_flat (regs_flat)
);

// File: tb/clkcfg_serial_slave_tb_top.sv
module clkcfg_serial_slave_tb_top;

    localparam int QTR = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_bus;
    logic        sda_oe;
    logic [47:0] regs_flat;
    logic [8:0]  out_en;
    logic        amp_sel;
    logic [2:0]  amp_code;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    logic [7:0] mdl [6];
    logic [7:0] wbuf [16];
    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    clkcfg_serial_slave dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .regs_flat (regs_flat),
        .out_en    (out_en),
        .amp_sel   (amp_sel),
        .amp_code  (amp_code)
    );

    function automatic logic [7:0] rv(input int i);
        case (i)
            1: return 8'h17; 2: return 8'hF8; 3: return 8'h08;
            4: return 8'h06; 5: return 8'hD8; default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] wm(input int i);
        case (i)
            1: return 8'h17; 2: return 8'hF8; 3: return 8'hFF;
            4: return 8'hFF; 5: return 8'hF0; default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic mdl_reset();
        for (int i = 0; i < 6; i++) mdl[i] = rv(i);
    endtask

    task automatic mdl_write(input int idx, input logic [7:0] v);
        if (idx < 6) mdl[idx] = (mdl[idx] & ~wm(idx)) | (v & wm(idx));
    endtask

    function automatic logic [7:0] mdl_read(input int idx);
        return (idx < 6) ? mdl[idx] : 8'h00;
    endfunction

    task automatic q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0;
        end
        sda_m = 1'b1; q(); scl_m = 1'b1; q();
        acked = (sda_bus == 1'b0);
        q(); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; q(); scl_m = 1'b1; q();
            b[i] = sda_bus;
            q(); scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0;
    endtask

    task automatic check_ports(input string req);
        logic [47:0] ef;
        logic [8:0]  eo;
        for (int i = 0; i < 6; i++) ef[8*i +: 8] = mdl[i];
        eo = {mdl[2][3], mdl[2][4], mdl[2][5], mdl[2][6], mdl[2][7],
              mdl[1][0], mdl[1][1], mdl[1][2], mdl[1][4]};
        chk(regs_flat === ef, req, "register image", regs_flat, ef);
        chk(out_en === eo, "R11", "output enables", out_en, eo);
        chk({amp_sel, amp_code} === {mdl[5][7], mdl[5][6:4]}, "R11", "amplitude fields",
            {amp_sel, amp_code}, {mdl[5][7], mdl[5][6:4]});
    endtask

    // Write transaction; n bytes after the command come from wbuf
    task automatic do_write(input logic [7:0] cmd, input int n, input string req);
        bit ack;
        int idx;
        int remain;
        int k0;
        bus_start();
        send_byte(8'hD6, ack); chk(ack, req, "address ack", ack, 1);
        send_byte(cmd, ack);   chk(ack, req, "command ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);
            chk(ack, req, "payload ack", ack, 1);
        end
        bus_stop();
        idx = int'(cmd[6:0]);
        if (cmd[7]) begin remain = 1; k0 = 0; end
        else begin remain = (n > 0) ? int'(wbuf[0]) : 0; k0 = 1; end
        for (int k = k0; k < n; k++) begin
            if (remain > 0) begin
                mdl_write(idx, wbuf[k]);
                idx++;
                remain--;
            end
        end
        q();
    endtask

    // Read transaction: expected bytes go to the scoreboard queue
    task automatic do_read(input logic [7:0] cmd, input int n, input string req);
        bit ack;
        logic [7:0] b;
        int idx;
        idx = int'(cmd[6:0]);
        bus_start();
        send_byte(8'hD6, ack); chk(ack, req, "address ack", ack, 1);
        send_byte(cmd, ack);   chk(ack, req, "command ack", ack, 1);
        bus_start();
        send_byte(8'hD7, ack); chk(ack, req, "read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            if (k == 0 && !cmd[7]) begin
                exp_q.push_back(mdl[4]);
            end else begin
                exp_q.push_back(mdl_read(idx));
                idx++;
            end
            tag_q.push_back(req);
            recv_byte(k < n - 1, b);
            act_q.push_back(b);
        end
        bus_stop();
        q();
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                logic [7:0] a;
                logic [7:0] e;
                string t;
                a = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected read byte", a, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(a === e, t, "read byte", a, e);
                end
            end
        end
    end

    // R12: SDA drive may only move while SCL is low
    initial begin
        logic prev_oe;
        logic prev_pd;
        prev_oe = 1'b0;
        prev_pd = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (sda_oe !== prev_oe) && !prev_pd)
                chk(scl_m == 1'b0, "R12", "SDA drive changed with SCL high", scl_m, 0);
            prev_oe = sda_oe;
            prev_pd = pwr_down;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        mdl_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        q();

        // R1 reset state and exported fields
        check_ports("R1");
        chk(sda_oe == 1'b0, "R1", "SDA released after reset", sda_oe, 0);

        // R2 foreign address is ignored
        bus_start();
        send_byte(8'hA0, ack);
        chk(!ack, "R2", "foreign address not acknowledged", ack, 0);
        send_byte(8'h81, ack);
        send_byte(8'h00, ack);
        bus_stop(); q();
        check_ports("R2");

        // R3 byte write clears output enables 0..3
        wbuf[0] = 8'h00;
        do_write(8'h81, 1, "R3");
        check_ports("R3");

        // R4 byte reads
        do_read(8'h83, 1, "R4");
        do_read(8'h81, 1, "R4");

        // R5/R7 block write all-ones and pattern against masks
        wbuf[0] = 8'd2; wbuf[1] = 8'hFF; wbuf[2] = 8'hAA;
        do_write(8'h01, 3, "R7");
        check_ports("R7");

        // R5 surplus byte beyond count is discarded
        wbuf[0] = 8'd1; wbuf[1] = 8'h09; wbuf[2] = 8'h77;
        do_write(8'h04, 3, "R5");
        check_ports("R5");

        // R6 block read: count register first, then registers from index 0
        do_read(8'h00, 7, "R6");

        // R7 reserved low nibble of register 5
        wbuf[0] = 8'h0F;
        do_write(8'h85, 1, "R7");
        check_ports("R7");
        wbuf[0] = 8'd1; wbuf[1] = 8'hA7;
        do_write(8'h05, 2, "R11");
        check_ports("R11");

        // R8 indices above 5
        wbuf[0] = 8'h5A;
        do_write(8'h87, 1, "R8");
        check_ports("R8");
        do_read(8'h86, 1, "R8");
        wbuf[0] = 8'd3; wbuf[1] = 8'h11; wbuf[2] = 8'h22; wbuf[3] = 8'h33;
        do_write(8'h05, 4, "R8");
        check_ports("R8");

        // R9 block write cut short after one data byte
        wbuf[0] = 8'd3; wbuf[1] = 8'h00;
        do_write(8'h02, 2, "R9");
        check_ports("R9");

        // R6/R8 block read running past the last register
        wbuf[0] = 8'h04;
        do_write(8'h84, 1, "R6");
        do_read(8'h04, 4, "R6");

        // R10 power-down restores reset image and releases SDA
        pwr_down = 1'b1;
        q();
        mdl_reset();
        check_ports("R10");
        chk(sda_oe == 1'b0, "R10", "SDA released in power-down", sda_oe, 0);
        pwr_down = 1'b0;
        q();
        do_read(8'h82, 1, "R10");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule